// File: doc/BRIEF.md
# USB Host Controller Register Bank with Interrupt Logic

This block is the I/O-mapped register file of a two-port full-speed USB host controller, together with the logic behind its interrupt line. A 32-byte window is decoded for byte, word and dword accesses. The block holds the command, status, interrupt-enable, frame-number, frame-list-base and start-of-frame timing registers. Port registers, descriptor processing and bus mastering are handled in other blocks.

A schedule engine sends the block one `frame_tick` pulse at the end of each frame, along with a two-bit completion mask. The mask bits report a completion-on-descriptor event and a short-packet event. The block tracks the run/halted state and advances the frame counter. It records the completion causes in a hidden two-bit register and drives a level interrupt. Error sources elsewhere in the controller set the remaining status bits through `evt_set`. The outputs `run`, `hc_reset` and `bus_reset` let the neighbouring blocks follow the software's command writes.

Top module: `usbh_regbank`

## Requirements
- R1: After `rst_n` is released, command, status, interrupt enable, frame number and frame-list base all read 0, SOF timing reads 0x40, and `irq`, `run`, `hc_reset` and `bus_reset` are all low.
- R2: A word write to offset 0x00 with bits 1 and 2 clear stores the value. `run` follows bit 0. When bit 0 goes from 0 to 1, status bit 5 (halted) clears. Writing bit 0 as 0 sets halted.
- R3: A `frame_tick` that arrives while `run` is low sets halted and leaves the frame number unchanged.
- R4: A `frame_tick` that arrives while `run` is high increments the frame number by one, modulo 2048.
- R5: A word write to offset 0x06 loads the low 11 bits into the frame number, but only while halted is set. At any other time the write has no effect.
- R6: The status register is at word offset 0x02. Bit 0 is transfer interrupt, 1 USB error, 2 resume, 3 host system error, 4 process error and 5 halted. Writing a 1 to a bit clears it. Writing a 1 to bit 0 also clears both hidden cause bits.
- R7: A `frame_tick` while running with a nonzero `frame_cause` ORs the mask into the cause register and sets status bit 0 on the same edge. A zero mask leaves bit 0 unchanged. If a clear of bit 0 falls on the same edge as such a tick, the new causes and bit 0 survive.
- R8: `evt_set` bits 0 to 3 set status bits 1 to 4. The enable register is at word offset 0x04 and keeps 4 bits. `irq` is high when any of these holds: cause0 with enable bit 2, cause1 with enable bit 3, USB error with enable bit 0, or resume with enable bit 1.
- R9: Host system error and process error drive `irq` whatever the enable register holds.
- R10: A dword write to offset 0x08 keeps bits 31:12. The frame-list base reads back with bits 11:0 as zero.
- R11: A byte access at offset 0x0C reads and writes the 8-bit SOF timing value.
- R12: Any access that does not match a register's offset and size is ignored on write. On read it returns 0xFF for a byte, 0xFF7F for a word, and 0xFFFFFFFF for a dword or for reserved size 3.
- R13: A command write with bit 1 set and bit 2 clear resets command, status, causes, enable and frame-list base, and loads SOF timing with 0x40, all on the write edge. The written value is not stored, the frame number is kept, and `hc_reset` is high for the one following cycle.
- R14: A command write with bit 2 set drives every `bus_reset` bit high for exactly the next cycle, while all registers are held. The register reset of R13 then happens on the edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| bus_addr | input | ADDR_W | Byte offset in the window |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, combinational, zero-extended |
| frame_tick | input | 1 | End-of-frame pulse from the schedule engine |
| frame_cause | input | 2 | Completion mask: bit 0 on-descriptor, bit 1 short packet |
| evt_set | input | 4 | Sets status bits 1..4 |
| irq | output | 1 | Level interrupt |
| run | output | 1 | Command run bit |
| hc_reset | output | 1 | One-cycle pulse after a register reset |
| bus_reset | output | NPORTS | One-cycle reset pulse for each port |
| frame_num | output | FRNUM_W | Current frame number |
| fl_base | output | 32 | Frame-list base address |
| sof_timing | output | 8 | SOF timing value |

## Verification
A software clear of status bit 0 and an end-of-frame tick carrying a nonzero mask can land on the same clock edge. Both act on bit 0 and on the hidden cause register. The bench drives the clearing write and the tick in the same cycle, once with each mask bit. It then judges the outcome through `irq`, switching the enable between bit 2 and bit 3. The new cause must be present and the older cause must be gone.

// File: rtl/usbh_rb_pkg.sv
package usbh_rb_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_WORD  = 2'd1,
        ACC_DWORD = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_size_e;

    // byte offsets inside the window
    localparam int OFS_CMD = 'h00;
    localparam int OFS_STS = 'h02;
    localparam int OFS_IEN = 'h04;
    localparam int OFS_FRN = 'h06;
    localparam int OFS_FLB = 'h08;
    localparam int OFS_SOF = 'h0C;

    // command bits
    localparam int CMD_RUN  = 0;
    localparam int CMD_HCR  = 1;
    localparam int CMD_GRST = 2;

    // status bits
    localparam int ST_XFER = 0;
    localparam int ST_UERR = 1;
    localparam int ST_RES  = 2;
    localparam int ST_HSE  = 3;
    localparam int ST_PERR = 4;
    localparam int ST_HALT = 5;
    localparam int ST_W    = 6;

    // interrupt enable bits
    localparam int IE_UERR  = 0;
    localparam int IE_RES   = 1;
    localparam int IE_XFER  = 2;
    localparam int IE_SHORT = 3;
    localparam int IEN_W    = 4;

    typedef enum logic [3:0] {
        RS_CMD, RS_STS, RS_IEN, RS_FRN, RS_FLB, RS_SOF,
        RS_UNB, RS_UNW, RS_UND
    } rsel_e;

    typedef struct packed {
        logic cmd;
        logic sts;
        logic ien;
        logic frn;
        logic flb;
        logic sof;
    } wr_strobe_t;

endpackage

// File: rtl/usbh_rb_decode.sv
module usbh_rb_decode
    import usbh_rb_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    output wr_strobe_t        stb,
    output rsel_e             rsel
);

    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'(OFS_IEN);
    localparam logic [ADDR_W-1:0] A_FRN = ADDR_W'(OFS_FRN);
    localparam logic [ADDR_W-1:0] A_FLB = ADDR_W'(OFS_FLB);
    localparam logic [ADDR_W-1:0] A_SOF = ADDR_W'(OFS_SOF);

    always_comb begin
        rsel = RS_UND;
        unique case (acc_size_e'(size))
            ACC_BYTE:  rsel = (addr == A_SOF) ? RS_SOF : RS_UNB;
            ACC_WORD: begin
                if      (addr == A_CMD) rsel = RS_CMD;
                else if (addr == A_STS) rsel = RS_STS;
                else if (addr == A_IEN) rsel = RS_IEN;
                else if (addr == A_FRN) rsel = RS_FRN;
                else                    rsel = RS_UNW;
            end
            ACC_DWORD: rsel = (addr == A_FLB) ? RS_FLB : RS_UND;
            default:   rsel = RS_UND;
        endcase

        stb = '0;
        if (sel && wr) begin
            case (rsel)
                RS_CMD:  stb.cmd = 1'b1;
                RS_STS:  stb.sts = 1'b1;
                RS_IEN:  stb.ien = 1'b1;
                RS_FRN:  stb.frn = 1'b1;
                RS_FLB:  stb.flb = 1'b1;
                RS_SOF:  stb.sof = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/usbh_rb_ctrl.sv
module usbh_rb_ctrl
    import usbh_rb_pkg::*;
#(
    parameter int NPORTS   = 2,
    parameter int FL_ALIGN = 12,
    parameter int SOF_RST  = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_cmd,
    input  logic                  wr_ien,
    input  logic                  wr_flb,
    input  logic                  wr_sof,
    input  logic [31:0]           wdata,
    output logic [15:0]           cmd_q,
    output logic [IEN_W-1:0]      ien_q,
    output logic [31-FL_ALIGN:0]  flb_q,
    output logic [7:0]            sof_q,
    output logic                  soft_rst,
    output logic                  run_start,
    output logic                  run_stop,
    output logic [NPORTS-1:0]     bus_reset,
    output logic                  hc_reset
);

    localparam int FLB_W = 32 - FL_ALIGN;

    typedef struct packed {
        logic [15:0]       cmd;
        logic [IEN_W-1:0]  ien;
        logic [FLB_W-1:0]  flb;
        logic [7:0]        sof;
        logic              gpend;
        logic              hcr;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic plain_cmd;

    assign plain_cmd = wr_cmd && !wdata[CMD_HCR] && !wdata[CMD_GRST] && !st_q.gpend;
    assign soft_rst  = st_q.gpend || (wr_cmd && wdata[CMD_HCR] && !wdata[CMD_GRST]);
    assign run_start = plain_cmd && wdata[CMD_RUN] && !st_q.cmd[CMD_RUN];
    assign run_stop  = plain_cmd && !wdata[CMD_RUN];

    always_comb begin
        st_d       = st_q;
        st_d.hcr   = soft_rst;
        st_d.gpend = 1'b0;
        if (soft_rst) begin
            st_d.cmd = '0;
            st_d.ien = '0;
            st_d.flb = '0;
            st_d.sof = 8'(SOF_RST);
        end else begin
            if (wr_cmd) begin
                if (wdata[CMD_GRST]) st_d.gpend = 1'b1;
                else                 st_d.cmd   = wdata[15:0];
            end
            if (wr_ien) st_d.ien = wdata[IEN_W-1:0];
            if (wr_flb) st_d.flb = wdata[31:FL_ALIGN];
            if (wr_sof) st_d.sof = wdata[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.sof <= 8'(SOF_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_q     = st_q.cmd;
    assign ien_q     = st_q.ien;
    assign flb_q     = st_q.flb;
    assign sof_q     = st_q.sof;
    assign bus_reset = {NPORTS{st_q.gpend}};
    assign hc_reset  = st_q.hcr;

    a_r14_bus_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && wdata[CMD_GRST] && !st_q.gpend) |=> (bus_reset == {NPORTS{1'b1}}));

    a_r14_reset_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.gpend |=> (st_q.cmd == '0 && st_q.sof == 8'(SOF_RST) && !st_q.gpend && st_q.hcr));

    a_r13_hcr_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && wdata[CMD_HCR] && !wdata[CMD_GRST]) |=> (st_q.cmd == '0 && hc_reset));

endmodule

// File: rtl/usbh_rb_status.sv
module usbh_rb_status
    import usbh_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              sts_wr,
    input  logic [ST_W-1:0]   w1c,
    input  logic              run_start,
    input  logic              run_stop,
    input  logic              tick,
    input  logic              running,
    input  logic [1:0]        cause_in,
    input  logic [3:0]        ev,
    input  logic [IEN_W-1:0]  ien,
    output logic [ST_W-1:0]   sts_q,
    output logic [1:0]        cause_q,
    output logic              irq
);

    logic [ST_W-1:0] sts_d;
    logic [1:0]      cause_d;

    always_comb begin
        sts_d   = sts_q;
        cause_d = cause_q;
        // software clears first, so events of the same edge survive
        if (sts_wr) begin
            sts_d = sts_d & ~w1c;
            if (w1c[ST_XFER]) cause_d = '0;
        end
        if (tick && !running) sts_d[ST_HALT] = 1'b1;
        if (run_start) sts_d[ST_HALT] = 1'b0;
        if (run_stop)  sts_d[ST_HALT] = 1'b1;
        if (tick && running && (cause_in != 2'b00)) begin
            cause_d          = cause_d | cause_in;
            sts_d[ST_XFER]   = 1'b1;
        end
        sts_d[ST_UERR] = sts_d[ST_UERR] | ev[0];
        sts_d[ST_RES]  = sts_d[ST_RES]  | ev[1];
        sts_d[ST_HSE]  = sts_d[ST_HSE]  | ev[2];
        sts_d[ST_PERR] = sts_d[ST_PERR] | ev[3];
        if (soft_rst) begin
            sts_d   = '0;
            cause_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q   <= '0;
            cause_q <= '0;
        end else begin
            sts_q   <= sts_d;
            cause_q <= cause_d;
        end
    end

    always_comb begin
        irq = (cause_q[0]     && ien[IE_XFER])  ||
              (cause_q[1]     && ien[IE_SHORT]) ||
              (sts_q[ST_UERR] && ien[IE_UERR])  ||
              (sts_q[ST_RES]  && ien[IE_RES])   ||
              sts_q[ST_HSE] || sts_q[ST_PERR];
    end

    a_r2_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (run_stop && !soft_rst) |=> sts_q[ST_HALT]);

    a_r2_start_unhalts: assert property (@(posedge clk) disable iff (!rst_n)
        (run_start && !soft_rst) |=> !sts_q[ST_HALT]);

    a_r3_idle_tick_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !running && !run_start && !soft_rst) |=> sts_q[ST_HALT]);

    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && w1c[ST_UERR] && !ev[0] && !soft_rst) |=> !sts_q[ST_UERR]);

    a_r7_cause_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && running && cause_in != 2'b00 && !soft_rst)
        |=> (sts_q[ST_XFER] && ((cause_q & $past(cause_in)) == $past(cause_in))));

endmodule

// File: rtl/usbh_rb_frame.sv
module usbh_rb_frame #(
    parameter int FRNUM_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frn_wr,
    input  logic [FRNUM_W-1:0] wval,
    input  logic               halted,
    input  logic               tick,
    input  logic               running,
    output logic [FRNUM_W-1:0] frn_q
);

    logic [FRNUM_W-1:0] frn_d;
    logic               load_ok;

    assign load_ok = frn_wr && halted;

    always_comb begin
        frn_d = frn_q;
        if (load_ok)               frn_d = wval;
        else if (tick && running)  frn_d = frn_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frn_q <= '0;
        else        frn_q <= frn_d;
    end

    a_r4_frame_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && running && !load_ok) |=> (frn_q == FRNUM_W'($past(frn_q) + 1'b1)));

    a_r5_locked_when_running: assert property (@(posedge clk) disable iff (!rst_n)
        (frn_wr && !halted && !(tick && running)) |=> $stable(frn_q));

endmodule

// File: rtl/usbh_regbank.sv
module usbh_regbank
    import usbh_rb_pkg::*;
#(
    parameter int NPORTS   = 2,
    parameter int ADDR_W   = 5,
    parameter int FRNUM_W  = 11,
    parameter int FL_ALIGN = 12,
    parameter int SOF_RST  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [1:0]         bus_size,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               frame_tick,
    input  logic [1:0]         frame_cause,
    input  logic [3:0]         evt_set,
    output logic               irq,
    output logic               run,
    output logic               hc_reset,
    output logic [NPORTS-1:0]  bus_reset,
    output logic [FRNUM_W-1:0] frame_num,
    output logic [31:0]        fl_base,
    output logic [7:0]         sof_timing
);

    localparam int FLB_W = 32 - FL_ALIGN;

    wr_strobe_t         stb;
    rsel_e              rsel;
    logic [15:0]        cmd_q;
    logic [IEN_W-1:0]   ien_q;
    logic [FLB_W-1:0]   flb_q;
    logic [7:0]         sof_q;
    logic               soft_rst, run_start, run_stop;
    logic [ST_W-1:0]    sts_q;
    logic [1:0]         cause_q;
    logic [FRNUM_W-1:0] frn_q;

    usbh_rb_decode #(.ADDR_W(ADDR_W)) u_decode (
        .sel  (bus_sel),
        .wr   (bus_wr),
        .size (bus_size),
        .addr (bus_addr),
        .stb  (stb),
        .rsel (rsel)
    );

    usbh_rb_ctrl #(
        .NPORTS   (NPORTS),
        .FL_ALIGN (FL_ALIGN),
        .SOF_RST  (SOF_RST)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cmd    (stb.cmd),
        .wr_ien    (stb.ien),
        .wr_flb    (stb.flb),
        .wr_sof    (stb.sof),
        .wdata     (bus_wdata),
        .cmd_q     (cmd_q),
        .ien_q     (ien_q),
        .flb_q     (flb_q),
        .sof_q     (sof_q),
        .soft_rst  (soft_rst),
        .run_start (run_start),
        .run_stop  (run_stop),
        .bus_reset (bus_reset),
        .hc_reset  (hc_reset)
    );

    usbh_rb_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .sts_wr    (stb.sts),
        .w1c       (bus_wdata[ST_W-1:0]),
        .run_start (run_start),
        .run_stop  (run_stop),
        .tick      (frame_tick),
        .running   (cmd_q[CMD_RUN]),
        .cause_in  (frame_cause),
        .ev        (evt_set),
        .ien       (ien_q),
        .sts_q     (sts_q),
        .cause_q   (cause_q),
        .irq       (irq)
    );

    usbh_rb_frame #(.FRNUM_W(FRNUM_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .frn_wr  (stb.frn),
        .wval    (bus_wdata[FRNUM_W-1:0]),
        .halted  (sts_q[ST_HALT]),
        .tick    (frame_tick),
        .running (cmd_q[CMD_RUN]),
        .frn_q   (frn_q)
    );

    always_comb begin
        unique case (rsel)
            RS_CMD:  bus_rdata = {16'h0, cmd_q};
            RS_STS:  bus_rdata = 32'(sts_q);
            RS_IEN:  bus_rdata = 32'(ien_q);
            RS_FRN:  bus_rdata = 32'(frn_q);
            RS_FLB:  bus_rdata = {flb_q, {FL_ALIGN{1'b0}}};
            RS_SOF:  bus_rdata = {24'h0, sof_q};
            RS_UNB:  bus_rdata = 32'h0000_00FF;
            RS_UNW:  bus_rdata = 32'h0000_FF7F;
            default: bus_rdata = 32'hFFFF_FFFF;
        endcase
    end

    assign run        = cmd_q[CMD_RUN];
    assign frame_num  = frn_q;
    assign fl_base    = {flb_q, {FL_ALIGN{1'b0}}};
    assign sof_timing = sof_q;

    a_r9_unmaskable_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_set[2] || evt_set[3]) && !soft_rst) |=> irq);

endmodule

// File: tb/tb_usbh_regbank.sv
module tb_usbh_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        frame_tick = 1'b0;
    logic [1:0]  frame_cause = '0;
    logic [3:0]  evt_set = '0;
    logic        irq, run, hc_reset;
    logic [1:0]  bus_reset;
    logic [10:0] frame_num;
    logic [31:0] fl_base;
    logic [7:0]  sof_timing;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [15:0] m_cmd, m_sts, m_ien, m_frn;
    logic [31:0] m_flb;
    logic [7:0]  m_sof;

    always #4 clk = ~clk;

    usbh_regbank dut (
        .clk, .rst_n, .bus_sel, .bus_wr, .bus_size, .bus_addr, .bus_wdata,
        .bus_rdata, .frame_tick, .frame_cause, .evt_set, .irq, .run,
        .hc_reset, .bus_reset, .frame_num, .fl_base, .sof_timing
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sz, input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sz, input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_size = sz; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [1:0] sz, input logic [4:0] a,
                         input logic [31:0] exp);
        logic [31:0] v;
        rd(sz, a, v);
        chk(req, v, exp);
    endtask

    task automatic tick(input logic [1:0] m);
        @(negedge clk);
        frame_tick = 1'b1; frame_cause = m;
        @(negedge clk);
        frame_tick = 1'b0; frame_cause = '0;
    endtask

    task automatic pulse_ev(input logic [3:0] e);
        @(negedge clk);
        evt_set = e;
        @(negedge clk);
        evt_set = '0;
    endtask

    // status clear and end-of-frame tick on the same edge
    task automatic clr_and_tick(input logic [1:0] m);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_size = 2'd1; bus_addr = 5'h02; bus_wdata = 32'h1;
        frame_tick = 1'b1; frame_cause = m;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; frame_tick = 1'b0; frame_cause = '0;
    endtask

    function automatic logic [31:0] exp_read(input logic [1:0] sz, input logic [4:0] a);
        case (sz)
            2'd0: return (a == 5'h0C) ? {24'h0, m_sof} : 32'hFF;
            2'd1: case (a)
                      5'h00:   return {16'h0, m_cmd};
                      5'h02:   return {16'h0, m_sts};
                      5'h04:   return {16'h0, m_ien};
                      5'h06:   return {16'h0, m_frn};
                      default: return 32'hFF7F;
                  endcase
            2'd2: return (a == 5'h08) ? m_flb : 32'hFFFF_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic exp_irq;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdchk("R1 cmd", 2'd1, 5'h00, 0);
        rdchk("R1 status", 2'd1, 5'h02, 0);
        rdchk("R1 ien", 2'd1, 5'h04, 0);
        rdchk("R1 frnum", 2'd1, 5'h06, 0);
        rdchk("R1 flbase", 2'd2, 5'h08, 0);
        rdchk("R1 sof", 2'd0, 5'h0C, 32'h40);
        chk("R1 outputs", {irq, run, hc_reset, bus_reset}, 0);

        // R2 run / halt
        wr(2'd1, 5'h00, 32'h1);
        chk("R2 run high", run, 1);
        rdchk("R2 not halted", 2'd1, 5'h02, 0);
        wr(2'd1, 5'h00, 32'h0);
        chk("R2 run low", run, 0);
        rdchk("R2 halted on stop", 2'd1, 5'h02, 32'h20);
        wr(2'd1, 5'h00, 32'h1);
        rdchk("R2 halted cleared on start", 2'd1, 5'h02, 0);
        rdchk("R2 cmd stored", 2'd1, 5'h00, 1);

        // R5 frame write while halted, R4 wrap
        wr(2'd1, 5'h00, 32'h0);
        wr(2'd1, 5'h06, 32'hFFFD);
        rdchk("R5 load while halted keeps 11 bits", 2'd1, 5'h06, 32'h7FD);
        wr(2'd1, 5'h00, 32'h1);
        for (int i = 0; i < 4; i++) tick(2'b00);
        rdchk("R4 wrap modulo 2048", 2'd1, 5'h06, 32'h001);
        chk("R4 frame_num port", frame_num, 11'h001);
        wr(2'd1, 5'h06, 32'h5);
        rdchk("R5 write ignored while running", 2'd1, 5'h06, 32'h001);
        rdchk("R7 zero mask leaves status", 2'd1, 5'h02, 0);

        // R3 idle tick halts
        wr(2'd1, 5'h00, 32'h0);
        wr(2'd1, 5'h02, 32'h20);
        rdchk("R6 halted cleared by W1C", 2'd1, 5'h02, 0);
        tick(2'b00);
        rdchk("R3 idle tick sets halted", 2'd1, 5'h02, 32'h20);
        rdchk("R3 frnum held", 2'd1, 5'h06, 32'h001);
        m_frn = 16'h1;

        // R8 sweep over every enable value and every maskable source
        wr(2'd1, 5'h00, 32'h1);
        for (int v = 0; v < 16; v++) begin
            wr(2'd1, 5'h04, v);
            for (int s = 0; s < 4; s++) begin
                case (s)
                    0: begin tick(2'b01); m_frn++; end
                    1: begin tick(2'b10); m_frn++; end
                    2: pulse_ev(4'b0001);
                    default: pulse_ev(4'b0010);
                endcase
                exp_irq = (s == 0) ? v[2] : (s == 1) ? v[3] : (s == 2) ? v[0] : v[1];
                chk($sformatf("R8 irq ien=%0d src=%0d", v, s), irq, exp_irq);
                wr(2'd1, 5'h02, 32'h3F);
            end
        end
        rdchk("R8 frame count after sweep", 2'd1, 5'h06, m_frn);

        // R6 status bit placement via events, R9 unmaskable
        wr(2'd1, 5'h04, 32'h0);
        pulse_ev(4'b0001);
        rdchk("R6 usb error bit 1", 2'd1, 5'h02, 32'h02);
        chk("R8 masked usb error", irq, 0);
        pulse_ev(4'b0100);
        chk("R9 host error irq", irq, 1);
        rdchk("R6 host error bit 3", 2'd1, 5'h02, 32'h0A);
        wr(2'd1, 5'h02, 32'h08);
        chk("R9 irq drops after clear", irq, 0);
        pulse_ev(4'b1000);
        chk("R9 process error irq", irq, 1);
        wr(2'd1, 5'h02, 32'h3F);
        chk("R6 all cleared", irq, 0);

        // R7 collision: clear of bit 0 and a new cause on the same edge
        wr(2'd1, 5'h04, 32'h4);
        tick(2'b01); m_frn++;
        clr_and_tick(2'b01); m_frn++;
        chk("R7 set wins over clear (irq)", irq, 1);
        rdchk("R7 set wins over clear (status)", 2'd1, 5'h02, 32'h01);
        wr(2'd1, 5'h02, 32'h01);
        chk("R6 W1C clears cause", irq, 0);
        tick(2'b01); m_frn++;
        clr_and_tick(2'b10); m_frn++;
        wr(2'd1, 5'h04, 32'h8);
        chk("R7 new short cause kept", irq, 1);
        wr(2'd1, 5'h04, 32'h4);
        chk("R7 old cause cleared", irq, 0);
        wr(2'd1, 5'h02, 32'h3F);

        // R10 R11 R12 sweep over the whole window
        wr(2'd2, 5'h08, 32'hABCD_E123);
        wr(2'd0, 5'h0C, 32'h5A);
        wr(2'd1, 5'h04, 32'h5);
        wr(2'd0, 5'h00, 32'h0);
        wr(2'd1, 5'h08, 32'hFFFF);
        wr(2'd2, 5'h0C, 32'hFFFF_FFFF);
        wr(2'd3, 5'h04, 32'hF);
        wr(2'd1, 5'h10, 32'h0);
        m_cmd = 16'h1; m_sts = 16'h0; m_ien = 16'h5;
        m_flb = 32'hABCD_E000; m_sof = 8'h5A;
        chk("R12 byte write at cmd ignored", run, 1);
        chk("R10 fl_base port", fl_base, 32'hABCD_E000);
        chk("R11 sof port", sof_timing, 8'h5A);
        for (int sz = 0; sz < 4; sz++)
            for (int a = 0; a < 32; a++)
                rdchk($sformatf("R12 read sz=%0d addr=0x%0h", sz, a), 2'(sz), 5'(a),
                      exp_read(2'(sz), 5'(a)));

        // R13 controller reset
        pulse_ev(4'b0010);
        wr(2'd1, 5'h00, 32'h3);
        chk("R13 run cleared", run, 0);
        chk("R13 hc_reset pulse", hc_reset, 1);
        @(negedge clk);
        chk("R13 hc_reset one cycle", hc_reset, 0);
        rdchk("R13 cmd not stored", 2'd1, 5'h00, 0);
        rdchk("R13 status cleared", 2'd1, 5'h02, 0);
        rdchk("R13 ien cleared", 2'd1, 5'h04, 0);
        rdchk("R13 flbase cleared", 2'd2, 5'h08, 0);
        rdchk("R13 sof reloaded", 2'd0, 5'h0C, 32'h40);
        rdchk("R13 frnum kept", 2'd1, 5'h06, m_frn);

        // R14 global reset
        wr(2'd1, 5'h00, 32'h1);
        wr(2'd0, 5'h0C, 32'h33);
        wr(2'd1, 5'h00, 32'h5);
        chk("R14 bus_reset pulse", bus_reset, 2'b11);
        chk("R14 run held during pulse", run, 1);
        chk("R14 sof held during pulse", sof_timing, 8'h33);
        chk("R14 no hc_reset yet", hc_reset, 0);
        @(negedge clk);
        chk("R14 bus_reset one cycle", bus_reset, 2'b00);
        chk("R14 hc_reset after pulse", hc_reset, 1);
        chk("R14 run cleared", run, 0);
        rdchk("R14 sof reloaded", 2'd0, 5'h0C, 32'h40);
        rdchk("R14 cmd not stored", 2'd1, 5'h00, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule